// File: doc/BRIEF.md
# Single-Shot Image Frame Capture Front End

This block sits in the pixel clock domain of a parallel-output image sensor and turns the sensor's sync strobes and pixel bus into write requests for a downstream FIFO. Software arms it by flipping a toggle line that crosses from the system clock domain through a short synchronizer chain. Once armed, the block does not start at once. It waits for the next rising edge of vertical sync, so that it never stores a partial frame. It then forwards every pixel sampled while the line-valid strobe is high and stops after one frame.

A frame ends when a parameterised number of lines has been seen, or earlier if another vertical sync rising edge arrives. The block then raises a frame-done level and flips a done toggle that the system domain can synchronise. Two counters report how many lines were captured and how many pixels the most recent line held. A mode input picks full 10-bit samples or only the upper 8 bits of each sample. If a pixel arrives while the FIFO reports full, a sticky overflow state is entered and writing stops until the block is re-armed.

The controller has five states. ST_IDLE is the state after reset. ST_WAIT_VS waits for frame start. ST_CAPTURE forwards pixels. ST_DONE and ST_OVERFLOW are the terminal states. The transitions are:
- arm (from any state to ST_WAIT_VS)
- frame start (ST_WAIT_VS to ST_CAPTURE, on a vertical sync rising edge)
- full-frame end and early end (ST_CAPTURE to ST_DONE)
- overrun (ST_CAPTURE to ST_OVERFLOW)

Top module: `frame_grab`

## Requirements
- R1: After reset the block is in ST_IDLE. In this state wr_en is 0, frame_done and overflow are 0, done_tgl is 0, and line_count and line_len are 0. Sync and pixel activity is ignored until the block is armed.
- R2: Any change of arm_tgl re-arms the block after two synchronizer flops plus one edge-detect flop. Re-arming enters ST_WAIT_VS and clears frame_done, overflow, line_count and line_len. It does not change done_tgl.
- R3: In ST_WAIT_VS, no write is issued even while href is high. Capture starts only on the first cycle in which vsync is sampled high after being low in the previous cycle.
- R4: In ST_CAPTURE, wr_en equals href AND NOT fifo_full, combinationally. This gives one write per pixel-clock cycle with href high.
- R5: With mode8 = 0, wr_data is pix_in[9:0]. With mode8 = 1, wr_data is {2'b00, pix_in[9:2]}.
- R6: In ST_CAPTURE, each cycle where href is sampled low after being high increments line_count. On that same edge, line_len takes the number of writes issued during that href-high run.
- R7: When line_count reaches LINES, the block enters ST_DONE. frame_done goes to 1 and done_tgl inverts once. No further write is issued until the block is re-armed.
- R8: A vsync rising edge seen in ST_CAPTURE ends the frame early and enters ST_DONE. This has the same effect on frame_done and done_tgl as R7, and line_count keeps the lines seen so far.
- R9: If href is high while fifo_full is 1 in ST_CAPTURE, the block enters ST_OVERFLOW. overflow then stays 1 and wr_en stays 0 until the block is re-armed. frame_done stays 0 in this case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Sensor pixel clock; clocks all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_tgl | input | 1 | Arm request from system domain; each change arms once |
| mode8 | input | 1 | 1 selects upper 8 bits of each sample |
| vsync | input | 1 | Vertical sync, frame start on rising edge |
| href | input | 1 | Line-valid strobe, pixel valid while high |
| pix_in | input | PIX_W | Sensor pixel data |
| fifo_full | input | 1 | Downstream FIFO full flag |
| wr_en | output | 1 | FIFO write request |
| wr_data | output | PIX_W | FIFO write data |
| frame_done | output | 1 | Frame complete level |
| done_tgl | output | 1 | Inverts once per completed frame, for domain crossing |
| overflow | output | 1 | Sticky overrun flag |
| line_count | output | LC_W | Lines captured in the current frame |
| line_len | output | PC_W | Pixels in the last completed line |

## Verification
The hardest case to reach is an arm that lands in the middle of a frame. Here the block must skip href-high lines until a fresh vsync rising edge appears. The bench re-arms and then immediately drives lines with no vsync, checking that no writes appear, before it starts a proper frame. An early vsync end and an overrun on a single full cycle inside a line are also hard to reach. These are driven as directed cases. Random frames with varied line lengths, line counts, modes and occasional full cycles follow.

// File: rtl/fg_pkg.sv
package fg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_VS,
        ST_CAPTURE,
        ST_DONE,
        ST_OVERFLOW
    } fg_state_e;
endpackage

// File: rtl/fg_arm_sync.sv
module fg_arm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic evt
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], tgl_in};
    end

    assign evt = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/fg_edge.sv
module fg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig;
    end

    assign rise = sig & ~prev;
    assign fall = ~sig & prev;
endmodule

// File: rtl/fg_geom_count.sv
module fg_geom_count #(
    parameter int LC_W = 9,
    parameter int PC_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            pix_inc,
    input  logic            line_end,
    output logic [LC_W-1:0] line_count,
    output logic [PC_W-1:0] line_len
);
    logic [PC_W-1:0] pix_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_run    <= '0;
            line_len   <= '0;
            line_count <= '0;
        end else if (clr) begin
            pix_run    <= '0;
            line_len   <= '0;
            line_count <= '0;
        end else if (line_end) begin
            line_len   <= pix_run;
            pix_run    <= '0;
            line_count <= line_count + 1'b1;
        end else if (pix_inc && pix_run != '1) begin
            pix_run <= pix_run + 1'b1;
        end
    end
endmodule

// File: rtl/frame_grab.sv
module frame_grab
    import fg_pkg::*;
#(
    parameter int PIX_W    = 10,
    parameter int NARROW_W = 8,
    parameter int LINES    = 480,
    parameter int MAX_PIX  = 640,
    parameter int SYNC_STG = 2,
    localparam int LC_W    = $clog2(LINES + 1),
    localparam int PC_W    = $clog2(MAX_PIX + 1)
) (
    input  logic             pclk,
    input  logic             rst_n,
    input  logic             arm_tgl,
    input  logic             mode8,
    input  logic             vsync,
    input  logic             href,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             fifo_full,
    output logic             wr_en,
    output logic [PIX_W-1:0] wr_data,
    output logic             frame_done,
    output logic             done_tgl,
    output logic             overflow,
    output logic [LC_W-1:0]  line_count,
    output logic [PC_W-1:0]  line_len
);
    localparam int PAD_W = PIX_W - NARROW_W;

    fg_state_e state, state_nx;
    logic arm_evt, vs_rise, vs_fall, hr_rise, hr_fall;
    logic last_line, line_end;

    fg_arm_sync #(.STAGES(SYNC_STG)) u_arm (
        .clk(pclk), .rst_n(rst_n), .tgl_in(arm_tgl), .evt(arm_evt)
    );

    fg_edge u_vs (
        .clk(pclk), .rst_n(rst_n), .sig(vsync), .rise(vs_rise), .fall(vs_fall)
    );

    fg_edge u_hr (
        .clk(pclk), .rst_n(rst_n), .sig(href), .rise(hr_rise), .fall(hr_fall)
    );

    assign last_line = (line_count == LC_W'(LINES - 1));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (arm_evt) begin
            state_nx = ST_WAIT_VS;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_WAIT_VS:  if (vs_rise) state_nx = ST_CAPTURE;
                ST_CAPTURE: begin
                    if (href && fifo_full)         state_nx = ST_OVERFLOW;
                    else if (vs_rise)              state_nx = ST_DONE;
                    else if (hr_fall && last_line) state_nx = ST_DONE;
                end
                ST_DONE:     state_nx = ST_DONE;
                ST_OVERFLOW: state_nx = ST_OVERFLOW;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register and done toggle
    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            done_tgl <= 1'b0;
        end else begin
            state <= state_nx;
            if (state != ST_DONE && state_nx == ST_DONE) done_tgl <= ~done_tgl;
        end
    end

    // outputs
    always_comb begin
        wr_en      = 1'b0;
        frame_done = 1'b0;
        overflow   = 1'b0;
        line_end   = 1'b0;
        unique case (state)
            ST_CAPTURE: begin
                wr_en    = href & ~fifo_full;
                line_end = hr_fall & ~vs_rise & ~arm_evt;
            end
            ST_DONE:     frame_done = 1'b1;
            ST_OVERFLOW: overflow   = 1'b1;
            default:     ;
        endcase
        wr_data = mode8 ? {{PAD_W{1'b0}}, pix_in[PIX_W-1 -: NARROW_W]} : pix_in;
    end

    fg_geom_count #(.LC_W(LC_W), .PC_W(PC_W)) u_cnt (
        .clk(pclk), .rst_n(rst_n), .clr(arm_evt),
        .pix_inc(wr_en), .line_end(line_end),
        .line_count(line_count), .line_len(line_len)
    );
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
    parameter int LINES = 480,
    parameter int LC_W  = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            arm_evt,
    input logic            href,
    input logic            fifo_full,
    input logic            wr_en,
    input logic            frame_done,
    input logic            done_tgl,
    input logic            overflow,
    input logic [LC_W-1:0] line_count
);
    assert_write_needs_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (href && !fifo_full));

    assert_no_write_after_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !wr_en);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !arm_evt) |=> overflow);

    assert_no_write_when_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !wr_en);

    assert_done_toggles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_done) |-> (done_tgl != $past(done_tgl)));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !arm_evt) |=> frame_done);

    assert_lines_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_count <= LC_W'(LINES));

    assert_rearm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_evt |=> (!overflow && !frame_done && line_count == '0));
endmodule

bind frame_grab fg_checker #(.LINES(LINES), .LC_W(LC_W)) u_fg_checker (
    .clk(pclk), .rst_n(rst_n), .arm_evt(arm_evt), .href(href),
    .fifo_full(fifo_full), .wr_en(wr_en), .frame_done(frame_done),
    .done_tgl(done_tgl), .overflow(overflow), .line_count(line_count)
);

// File: tb/test_frame_grab.sv
module test_frame_grab;
    localparam int LINES = 5;
    localparam int LC_W  = $clog2(LINES + 1);
    localparam int PC_W  = $clog2(640 + 1);

    logic pclk = 1'b0, rst_n = 1'b0, arm_tgl = 1'b0, mode8 = 1'b0;
    logic vsync = 1'b0, href = 1'b0, fifo_full = 1'b0;
    logic [9:0] pix_in = '0;
    logic wr_en, frame_done, done_tgl, overflow;
    logic [9:0] wr_data;
    logic [LC_W-1:0] line_count;
    logic [PC_W-1:0] line_len;

    frame_grab #(.LINES(LINES)) i_frame_grab (
        .pclk(pclk), .rst_n(rst_n), .arm_tgl(arm_tgl), .mode8(mode8),
        .vsync(vsync), .href(href), .pix_in(pix_in), .fifo_full(fifo_full),
        .wr_en(wr_en), .wr_data(wr_data), .frame_done(frame_done),
        .done_tgl(done_tgl), .overflow(overflow),
        .line_count(line_count), .line_len(line_len)
    );

    always #10 pclk = ~pclk;

    int n_run = 0, n_fail = 0, cycles = 0;
    bit finished = 1'b0;

    // model: 0 idle, 1 wait, 2 capture, 3 done, 4 overflow
    int m_st = 0, m_lines = 0, m_len = 0, m_run = 0;
    bit m_tgl = 0, m_vsp = 0, m_hrp = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_data(bit m8, int px);
        return m8 ? (px >> 2) : px;
    endfunction

    task automatic cyc(bit vs, bit hr, int px, bit full);
        bit exp_wr, vr, hf;
        @(negedge pclk);
        vsync = vs; href = hr; pix_in = 10'(px); fifo_full = full;
        #2;
        exp_wr = (m_st == 2) && hr && !full;
        chk(wr_en == exp_wr, (m_st == 2) ? "R4 wr_en" : "R3/R7 wr_en idle", wr_en, exp_wr);
        if (exp_wr) chk(wr_data == 10'(exp_data(mode8, px)), "R5 wr_data", wr_data, exp_data(mode8, px));
        vr = vs && !m_vsp;
        hf = !hr && m_hrp;
        if (m_st == 1 && vr) m_st = 2;
        else if (m_st == 2) begin
            if (hr && full) m_st = 4;
            else if (vr) begin m_st = 3; m_tgl = !m_tgl; end
            else if (hr) m_run++;
            else if (hf) begin
                m_len = m_run; m_run = 0; m_lines++;
                if (m_lines == LINES) begin m_st = 3; m_tgl = !m_tgl; end
            end
        end
        m_vsp = vs; m_hrp = hr;
        @(posedge pclk); #1;
        cycles++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    task automatic status(string tag);
        chk(frame_done == (m_st == 3), {tag, " frame_done"}, frame_done, m_st == 3);
        chk(overflow == (m_st == 4), {tag, " overflow"}, overflow, m_st == 4);
        chk(done_tgl == m_tgl, {tag, " done_tgl"}, done_tgl, m_tgl);
        chk(line_count == LC_W'(m_lines), {tag, " line_count"}, line_count, m_lines);
        chk(line_len == PC_W'(m_len), {tag, " line_len"}, line_len, m_len);
    endtask

    task automatic arm();
        @(negedge pclk);
        arm_tgl = !arm_tgl;
        idle(4);
        m_st = 1; m_lines = 0; m_len = 0; m_run = 0;
    endtask

    task automatic lines(int nl, int maxlen, int fullpct);
        for (int l = 0; l < nl; l++) begin
            idle(2);
            for (int p = 0, len = 1 + int'($urandom % maxlen); p < len; p++)
                cyc(0, 1, int'($urandom % 1024), int'($urandom % 100) < fullpct);
        end
        idle(2);
    endtask

    task automatic vs_pulse();
        cyc(1, 0, 0, 0); cyc(1, 0, 0, 0); idle(2);
    endtask

    initial begin
        void'($urandom(32'd2024));
        idle(1);
        #3 rst_n = 1'b1;
        idle(2);
        status("R1 reset");
        // unarmed activity ignored
        vs_pulse(); lines(2, 6, 0);
        status("R1 unarmed");
        // full frame
        arm(); status("R2 armed");
        vs_pulse(); lines(LINES, 9, 0);
        status("R6/R7 full frame");
        lines(2, 5, 0); vs_pulse(); lines(1, 5, 0);
        status("R7 stopped");
        // mid-frame arm: lines before vsync must not be stored
        arm(); lines(3, 7, 0);
        status("R3 waiting");
        vs_pulse(); mode8 = 1'b1; lines(LINES, 8, 0);
        status("R5/R7 narrow frame");
        mode8 = 1'b0;
        // early end on vsync
        arm(); vs_pulse(); lines(3, 6, 0); vs_pulse();
        status("R8 early end");
        // overflow
        arm(); vs_pulse(); lines(1, 5, 0);
        idle(1); cyc(0, 1, 5, 0); cyc(0, 1, 6, 1); cyc(0, 1, 7, 0); idle(2);
        status("R9 overflow");
        lines(2, 4, 0);
        status("R9 sticky");
        arm(); status("R2 rearm clears");
        // random frames
        for (int f = 0; f < 30; f++) begin
            mode8 = ($urandom % 2) == 1;
            if (($urandom % 4) != 0) arm();
            vs_pulse();
            lines(1 + int'($urandom % (LINES + 1)), 12, int'($urandom % 3));
            status("R4/R6 random");
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge pclk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected 0", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule